// File: doc/BRIEF.md
# Privilege-Gated Interrupt Priority Controller

This block keeps a pending-interrupt vector for each of seven interrupt sources and picks one winner to service. Software and hardware agents raise a source bit through a post port and drop it through a clear port. A clear-all strobe empties everything at once. A one-bit summary per source records whether that source still has any bit pending.

Which sources may win, and in which order, depends on two processor state inputs: hypervisor-privileged mode and interrupt-enable. The take flag, the winning source code and a 4-bit software interrupt level are derived combinationally from the stored state and those two inputs. A read port returns the complete vector of any selected source in the same cycle.

Top module: `irq_prio_ctl`

## Requirements
- R1: A post (post_en=1) sets bit post_idx of source post_type's vector on the next clock edge and marks that source pending. Source codes are: 0 hypervisor tick match, 1 interrupt vector, 2 trap-level-zero, 3 CPU mondo, 4 device mondo, 5 software interrupt, 6 resumable error. A post with code 7 changes nothing.
- R2: A clear (clr_en=1) resets bit clr_idx of source clr_type's vector. The source stays pending while any other bit of its vector remains set, and stops being pending once the vector is zero.
- R3: When a post and a clear hit the same source and bit in the same cycle, the bit ends up set.
- R4: Reset and clr_all both leave every vector at zero and no source pending. clr_all overrides a post or a clear in the same cycle.
- R5: With no source pending, take is 0 and win_type is 7, whatever hpriv and ie are. In every case take is 1 exactly when win_type is not 7.
- R6: With hpriv=1, only source 0 and then source 1 can win, and only when ie=1. Otherwise no interrupt is taken.
- R7: With hpriv=0, source 2 beats 0, and 0 beats 1. These three win regardless of ie.
- R8: With hpriv=0 and ie=1, and none of sources 2, 0 and 1 pending, the order is 3, then 4, then 5, then 6. With ie=0, sources 3 to 6 never win.
- R9: soft_lvl is 14 when bit 0 or bit 16 of the software interrupt vector is set. Otherwise it is the highest set bit among bits 15 down to 1, or 0 if none of those is set. Bits 17 to 63 have no effect on it.
- R10: rd_vec returns the vector of source rd_type in the same cycle. rd_type=7 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_en | input | 1 | Post strobe |
| post_type | input | 3 | Source code for the post |
| post_idx | input | 6 | Bit index for the post |
| clr_en | input | 1 | Clear strobe |
| clr_type | input | 3 | Source code for the clear |
| clr_idx | input | 6 | Bit index for the clear |
| clr_all | input | 1 | Empty all vectors |
| hpriv | input | 1 | Hypervisor-privileged mode |
| ie | input | 1 | Interrupt enable |
| take | output | 1 | An interrupt is to be taken |
| win_type | output | 3 | Winning source code, 7 for none |
| soft_lvl | output | 4 | Software interrupt level |
| rd_type | input | 3 | Source selected for readback |
| rd_vec | output | 64 | Vector of the selected source |

## Verification
Post, clear and clear-all act on the first rising edge after they are presented. Take, win_type, soft_lvl and rd_vec follow that state, and follow hpriv, ie and rd_type with no register in between. The bench drives strobes at the falling edge and samples one time unit after the rising edge. It changes the mode and read-select inputs only while no strobe is active, and checks after a short settle delay. Every subset of the seven sources is swept under all four mode combinations against an arithmetic reference.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned NUM_SRC = 7;
  localparam int unsigned SRC_W   = 3;
  localparam int unsigned LVL_W   = 4;

  typedef enum logic [SRC_W-1:0] {
    SRC_HTICK  = 3'd0,
    SRC_IVEC   = 3'd1,
    SRC_TLZ    = 3'd2,
    SRC_CMONDO = 3'd3,
    SRC_DMONDO = 3'd4,
    SRC_SOFT   = 3'd5,
    SRC_RESERR = 3'd6,
    SRC_NONE   = 3'd7
  } src_e;
endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store
  import irq_prio_pkg::*;
#(
  parameter int unsigned VEC_W = 64,
  localparam int unsigned IDX_W = $clog2(VEC_W)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            post_en,
  input  logic [SRC_W-1:0]                post_type,
  input  logic [IDX_W-1:0]                post_idx,
  input  logic                            clr_en,
  input  logic [SRC_W-1:0]                clr_type,
  input  logic [IDX_W-1:0]                clr_idx,
  input  logic                            clr_all,
  output logic [NUM_SRC-1:0][VEC_W-1:0]   pend,
  output logic [NUM_SRC-1:0]              summ
);
  localparam logic [VEC_W-1:0] ONE = {{(VEC_W-1){1'b0}}, 1'b1};

  for (genvar t = 0; t < NUM_SRC; t++) begin : g_src
    logic             set_hit, clr_hit, ld;
    logic [VEC_W-1:0] set_m, clr_m, vec_nxt;
    logic             sum_nxt;

    always_comb begin
      set_hit = post_en && (post_type == SRC_W'(t));
      clr_hit = clr_en  && (clr_type  == SRC_W'(t));
      set_m   = set_hit ? (ONE << post_idx) : '0;
      clr_m   = clr_hit ? (ONE << clr_idx)  : '0;
      ld      = clr_all || set_hit || clr_hit;
      if (clr_all) begin
        vec_nxt = '0;
        sum_nxt = 1'b0;
      end else begin
        vec_nxt = (pend[t] & ~clr_m) | set_m;
        if (set_hit)      sum_nxt = 1'b1;
        else if (clr_hit) sum_nxt = |vec_nxt;
        else              sum_nxt = summ[t];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[t] <= '0;
        summ[t] <= 1'b0;
      end else if (ld) begin
        pend[t] <= vec_nxt;
        summ[t] <= sum_nxt;
      end
    end
  end
endmodule

// File: rtl/irq_soft_level.sv
module irq_soft_level
  import irq_prio_pkg::*;
#(
  parameter int unsigned VEC_W = 64
) (
  input  logic [VEC_W-1:0] soft_vec,
  output logic [LVL_W-1:0] lvl
);
  localparam int unsigned TOP_LVL = (1 << LVL_W) - 1;
  localparam int unsigned ALIAS_B = TOP_LVL + 1;
  localparam logic [LVL_W-1:0] ALIAS_LVL = LVL_W'(TOP_LVL - 1);

  always_comb begin
    lvl = '0;
    for (int i = 1; i <= TOP_LVL; i++) begin
      if (soft_vec[i]) lvl = LVL_W'(i);
    end
    if (soft_vec[0] || soft_vec[ALIAS_B]) lvl = ALIAS_LVL;
  end
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_prio_pkg::*;
(
  input  logic [NUM_SRC-1:0] summ,
  input  logic               hpriv,
  input  logic               ie,
  output logic               take,
  output logic [SRC_W-1:0]   win_type
);
  src_e win;

  always_comb begin
    win = SRC_NONE;
    if (|summ) begin
      if (hpriv) begin
        if (ie) begin
          if (summ[SRC_HTICK])     win = SRC_HTICK;
          else if (summ[SRC_IVEC]) win = SRC_IVEC;
        end
      end else begin
        if (summ[SRC_TLZ])         win = SRC_TLZ;
        else if (summ[SRC_HTICK])  win = SRC_HTICK;
        else if (summ[SRC_IVEC])   win = SRC_IVEC;
        else if (ie) begin
          if (summ[SRC_CMONDO])      win = SRC_CMONDO;
          else if (summ[SRC_DMONDO]) win = SRC_DMONDO;
          else if (summ[SRC_SOFT])   win = SRC_SOFT;
          else if (summ[SRC_RESERR]) win = SRC_RESERR;
        end
      end
    end
    win_type = win;
    take     = (win != SRC_NONE);
  end
endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
  import irq_prio_pkg::*;
#(
  parameter int unsigned VEC_W = 64,
  localparam int unsigned IDX_W = $clog2(VEC_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               post_en,
  input  logic [SRC_W-1:0]   post_type,
  input  logic [IDX_W-1:0]   post_idx,
  input  logic               clr_en,
  input  logic [SRC_W-1:0]   clr_type,
  input  logic [IDX_W-1:0]   clr_idx,
  input  logic               clr_all,
  input  logic               hpriv,
  input  logic               ie,
  output logic               take,
  output logic [SRC_W-1:0]   win_type,
  output logic [LVL_W-1:0]   soft_lvl,
  input  logic [SRC_W-1:0]   rd_type,
  output logic [VEC_W-1:0]   rd_vec
);
  logic [NUM_SRC-1:0][VEC_W-1:0] pend;
  logic [NUM_SRC-1:0]            summ;

  irq_pend_store #(.VEC_W(VEC_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .post_en(post_en), .post_type(post_type), .post_idx(post_idx),
    .clr_en(clr_en), .clr_type(clr_type), .clr_idx(clr_idx),
    .clr_all(clr_all), .pend(pend), .summ(summ)
  );

  irq_soft_level #(.VEC_W(VEC_W)) u_lvl (
    .soft_vec(pend[SRC_SOFT]), .lvl(soft_lvl)
  );

  irq_select u_sel (
    .summ(summ), .hpriv(hpriv), .ie(ie), .take(take), .win_type(win_type)
  );

  always_comb begin
    rd_vec = '0;
    for (int t = 0; t < NUM_SRC; t++) begin
      if (rd_type == SRC_W'(t)) rd_vec = pend[t];
    end
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               post_en,
  input logic [SRC_W-1:0]   post_type,
  input logic               clr_all,
  input logic               hpriv,
  input logic               ie,
  input logic               take,
  input logic [SRC_W-1:0]   win_type,
  input logic [NUM_SRC-1:0] summ
);
  p_post_marks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (post_en && !clr_all && post_type != SRC_NONE) |=> summ[$past(post_type)]);

  p_clrall_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (summ == '0));

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (summ == '0) |-> (!take && win_type == SRC_NONE));

  p_take_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take == (win_type != SRC_NONE));

  p_hpriv_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hpriv) |-> (ie && (win_type == SRC_HTICK || win_type == SRC_IVEC)));

  p_tlz_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hpriv && summ[SRC_TLZ]) |-> (win_type == SRC_TLZ));

  p_noie_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hpriv && !ie) |-> (win_type <= SRC_TLZ));
endmodule

bind irq_prio_ctl irq_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .post_en(post_en), .post_type(post_type),
  .clr_all(clr_all), .hpriv(hpriv), .ie(ie), .take(take),
  .win_type(win_type), .summ(summ)
);

// File: tb/test_irq_prio_ctl.sv
module test_irq_prio_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        post_en = 0, clr_en = 0, clr_all = 0, hpriv = 0, ie = 0;
  logic [2:0]  post_type = 0, clr_type = 0, rd_type = 0;
  logic [5:0]  post_idx = 0, clr_idx = 0;
  logic        take;
  logic [2:0]  win_type;
  logic [3:0]  soft_lvl;
  logic [63:0] rd_vec;

  logic [63:0] ref_v [NS];
  int n_chk = 0, n_bad = 0, cycles = 0;

  irq_prio_ctl i_irq_prio_ctl (
    .clk(clk), .rst_n(rst_n), .post_en(post_en), .post_type(post_type),
    .post_idx(post_idx), .clr_en(clr_en), .clr_type(clr_type), .clr_idx(clr_idx),
    .clr_all(clr_all), .hpriv(hpriv), .ie(ie), .take(take), .win_type(win_type),
    .soft_lvl(soft_lvl), .rd_type(rd_type), .rd_vec(rd_vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_win(logic hp, logic en);
    logic [6:0] p;
    for (int t = 0; t < NS; t++) p[t] = (ref_v[t] != 0);
    if (hp) begin
      if (!en) return 3'd7;
      if (p[0]) return 3'd0;
      if (p[1]) return 3'd1;
      return 3'd7;
    end
    if (p[2]) return 3'd2;
    if (p[0]) return 3'd0;
    if (p[1]) return 3'd1;
    if (!en) return 3'd7;
    for (int t = 3; t < NS; t++) if (p[t]) return 3'(t);
    return 3'd7;
  endfunction

  function automatic logic [3:0] exp_lvl();
    logic [63:0] s = ref_v[5];
    if (s[0] || s[16]) return 4'd14;
    for (int i = 15; i >= 1; i--) if (s[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic op(logic pe, logic [2:0] pt, logic [5:0] pi,
                    logic ce, logic [2:0] ct, logic [5:0] ci, logic ca);
    @(negedge clk);
    post_en = pe; post_type = pt; post_idx = pi;
    clr_en = ce; clr_type = ct; clr_idx = ci; clr_all = ca;
    @(posedge clk);
    #1;
    post_en = 0; clr_en = 0; clr_all = 0;
    if (ca) begin
      for (int t = 0; t < NS; t++) ref_v[t] = '0;
    end else begin
      if (ce && ct < 3'd7) ref_v[ct][ci] = 1'b0;
      if (pe && pt < 3'd7) ref_v[pt][pi] = 1'b1;
    end
  endtask

  task automatic check_state(string ctx, bit do_rd);
    for (int m = 0; m < 4; m++) begin
      string tag;
      logic [2:0] ew;
      hpriv = m[1]; ie = m[0];
      #1;
      ew = exp_win(hpriv, ie);
      if (ew == 3'd7 && !(hpriv && !ie) && !(!hpriv && !ie)) tag = "R5";
      else if (hpriv) tag = "R6";
      else if (!ie)   tag = "R7";
      else            tag = "R8";
      chk({ctx, " ", tag, " win_type"}, 64'(win_type), 64'(ew));
      chk({ctx, " R5 take"}, 64'(take), 64'(ew != 3'd7));
    end
    chk({ctx, " R9 soft_lvl"}, 64'(soft_lvl), 64'(exp_lvl()));
    if (do_rd) begin
      for (int r = 0; r < 8; r++) begin
        rd_type = 3'(r);
        #1;
        chk({ctx, (r == 7) ? " R10 rd_vec code7" : " R1 R10 rd_vec"}, rd_vec,
            (r == 7) ? 64'd0 : ref_v[r]);
      end
    end
  endtask

  initial begin
    for (int t = 0; t < NS; t++) ref_v[t] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 check_state("reset R4", 1);

    // sweep every subset of sources under every mode
    for (int s = 0; s < 128; s++) begin
      op(0, 0, 0, 0, 0, 0, 1);
      for (int t = 0; t < NS; t++)
        if (s[t]) op(1, 3'(t), 6'((s * 3 + t * 7) % 64), 0, 0, 0, 0);
      check_state("sweep", (s % 9) == 0);
    end

    // R2 partial clear keeps source pending
    op(0, 0, 0, 0, 0, 0, 1);
    op(1, 3, 6'd40, 0, 0, 0, 0);
    op(1, 3, 6'd2, 0, 0, 0, 0);
    op(0, 0, 0, 1, 3, 6'd40, 0);
    check_state("R2 partial", 1);
    op(0, 0, 0, 1, 3, 6'd2, 0);
    check_state("R2 emptied", 1);

    // R3 same bit post and clear
    op(1, 6, 6'd9, 1, 6, 6'd9, 0);
    check_state("R3 post wins", 1);
    op(1, 6, 6'd9, 1, 6, 6'd9, 0);
    check_state("R3 again", 1);

    // R4 clear-all beats post
    op(1, 2, 6'd1, 0, 0, 0, 1);
    check_state("R4 clrall over post", 1);

    // R1 code 7 ignored
    op(1, 7, 6'd5, 0, 0, 0, 0);
    check_state("R1 code7 post", 1);

    // R9 single bits and pairs
    for (int i = 0; i < 64; i++) begin
      op(0, 0, 0, 0, 0, 0, 1);
      op(1, 5, 6'(i), 0, 0, 0, 0);
      check_state("R9 single", 0);
    end
    for (int i = 1; i < 16; i++)
      for (int j = i + 1; j < 18; j++) begin
        op(0, 0, 0, 0, 0, 0, 1);
        op(1, 5, 6'(i), 0, 0, 0, 0);
        op(1, 5, 6'(j), 0, 0, 0, 0);
        check_state("R9 pair", 0);
      end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule